// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Controller

The controller takes nine level-sensitive interrupt sources and routes them onto three interrupt request outputs. Each raw source first goes through a two-flop synchronizer. It is then turned into an "active" flag using a per-source polarity. Three of the sources have a polarity that is fixed and cannot be changed. Each output line has its own register. The register holds one enable bit per source and one pending bit per source. A pending bit latches while its source is active and enabled on that line. The line's request output is high while any of its pending bits is set.

Software uses a small synchronous 32-bit register port with an address, a write strobe, write data and read data. Read data is combinational from the address. A handler reads a line register to find which sources are pending. It then writes ones to those pending bits to acknowledge them. To initialise a line, software writes ones to its whole pending field and zeros to its enables.

Top module: `irq_router`

## Requirements
- R1: After synchronous reset, the polarity register, every enable bit and every pending bit are zero, all reads return zero and `irq_out` is zero.
- R2: Bits 8:0 of the register at byte address 0x0 give the polarity of each configurable source. A one means the source is active when its input is high. A zero means it is active when its input is low. Reads return the stored bits in 8:0 and zeros everywhere else.
- R3: Sources 1 and 8 are always active when high, and source 2 is always active when low, whatever their polarity bits hold.
- R4: The register for line k (k = 0, 1, 2) is at byte address 4*(k+1). Bits 8:0 hold the enables for sources 0..8 and bits 24:16 hold the pending bits. A write loads bits 8:0 into the enables. All other read bits are zero.
- R5: A pending bit sets when its source is active and enabled on that line. It then stays set after the source goes inactive, until it is acknowledged.
- R6: Writing a one to pending bit 16+n of a line register clears that bit in the next cycle. Writing a zero there leaves it unchanged. If the source is still active and enabled, the bit sets again one cycle later.
- R7: `irq_out[k]` is high exactly when line k has at least one pending bit set.
- R8: Writing 0x01FF0000 to a line register clears all enables and all pending bits of that line and leaves the other lines as they were.
- R9: A change on a raw source reaches the pending bit on the third rising clock edge after it. It does not show on `irq_out` after only two edges.
- R10: Writes to byte addresses 0x10 and above have no effect, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 5 | Byte address of the register |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| src_raw | input | 9 | Raw interrupt source levels |
| irq_out | output | 3 | Interrupt request per line, active high |

## Verification
On every cycle, the assertions check several per-bit rules. A pending bit may only rise when its enable and its active flag were both set in the cycle before. An acknowledge always clears its bit. A pending bit that is not acknowledged never drops. The init write empties its line, and a reset cycle leaves every request low. The polarity mapping, including the three fixed-polarity sources, can only be shown by the bench scenarios. So can the synchronizer latency, the register layout and readback, the re-assertion of a bit acknowledged while its source is still active, and the fact that other lines and unmapped addresses are left alone. For these, the bench sweeps every source over every line under both polarity settings.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    parameter int NUM_SRC  = 9;
    parameter int NUM_LINE = 3;
    parameter int PEND_LSB = 16;
    parameter int DATA_W   = 32;
    parameter int ADDR_W   = 5;

    // Sources whose active level is hard-wired, and which of those are high
    localparam logic [NUM_SRC-1:0] FIXED_MASK = 9'b1_0000_0110;
    localparam logic [NUM_SRC-1:0] FIXED_HIGH = 9'b1_0000_0010;

    typedef enum logic [1:0] {
        SEL_POL  = 2'd0,
        SEL_LINE = 2'd1,
        SEL_NONE = 2'd2
    } reg_sel_e;

    // Word 0 is the polarity register, words 1..nline are line registers
    function automatic reg_sel_e decode_word(input int unsigned word,
                                             input int unsigned nline);
        if (word == 0)
            return SEL_POL;
        else if (word <= nline)
            return SEL_LINE;
        else
            return SEL_NONE;
    endfunction

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/irq_polarity.sv
module irq_polarity #(
    parameter int           W          = 9,
    parameter logic [W-1:0] FIXED_MASK = '0,
    parameter logic [W-1:0] FIXED_HIGH = '0
) (
    input  logic [W-1:0] level,
    input  logic [W-1:0] pol_cfg,
    output logic [W-1:0] active
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (FIXED_MASK[i]) begin : g_fixed
                if (FIXED_HIGH[i]) begin : g_hi
                    assign active[i] = level[i];
                end else begin : g_lo
                    assign active[i] = ~level[i];
                end
            end else begin : g_cfg
                assign active[i] = pol_cfg[i] ? level[i] : ~level[i];
            end
        end
    endgenerate
endmodule

// File: rtl/irq_line_reg.sv
module irq_line_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wr_en_bits,
    input  logic [W-1:0] wr_ack_bits,
    input  logic [W-1:0] active,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pend_q,
    output logic         req
);
    logic [W-1:0] ack;
    logic [W-1:0] pend_d;

    always_comb begin
        ack    = wr ? wr_ack_bits : '0;
        // acknowledge wins over a new set in the same cycle
        pend_d = (pend_q | (active & en_q)) & ~ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            if (wr)
                en_q <= wr_en_bits;
            pend_q <= pend_d;
        end
    end

    assign req = |pend_q;
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_SRC  = NUM_SRC,
    parameter int N_LINE = NUM_LINE,
    parameter int P_LSB  = PEND_LSB,
    parameter int DW     = DATA_W,
    parameter int AW     = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [N_SRC-1:0]  src_raw,
    output logic [N_LINE-1:0] irq_out
);
    localparam int WORD_W = AW - 2;
    localparam int IDX_W  = (N_LINE > 1) ? $clog2(N_LINE) : 1;

    logic [WORD_W-1:0] word;
    reg_sel_e          sel;
    logic [IDX_W-1:0]  line_idx;

    logic [N_SRC-1:0] pol_q;
    logic [N_SRC-1:0] src_sync;
    logic [N_SRC-1:0] src_act;

    logic [N_SRC-1:0] en_arr   [N_LINE];
    logic [N_SRC-1:0] pend_arr [N_LINE];
    logic [N_LINE*N_SRC-1:0] line_en;
    logic [N_LINE*N_SRC-1:0] line_pend;

    assign word     = reg_addr[AW-1:2];
    assign sel      = decode_word(32'(word), N_LINE);
    assign line_idx = IDX_W'(32'(word) - 32'd1);

    always_ff @(posedge clk) begin
        if (rst)
            pol_q <= '0;
        else if (reg_we && sel == SEL_POL)
            pol_q <= reg_wdata[N_SRC-1:0];
    end

    irq_sync2 #(.W(N_SRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_raw),
        .q   (src_sync)
    );

    irq_polarity #(
        .W          (N_SRC),
        .FIXED_MASK (FIXED_MASK),
        .FIXED_HIGH (FIXED_HIGH)
    ) u_pol (
        .level   (src_sync),
        .pol_cfg (pol_q),
        .active  (src_act)
    );

    genvar k;
    generate
        for (k = 0; k < N_LINE; k++) begin : g_line
            logic hit;
            assign hit = reg_we && (sel == SEL_LINE) && (line_idx == IDX_W'(k));

            irq_line_reg #(.W(N_SRC)) u_line (
                .clk         (clk),
                .rst         (rst),
                .wr          (hit),
                .wr_en_bits  (reg_wdata[N_SRC-1:0]),
                .wr_ack_bits (reg_wdata[P_LSB +: N_SRC]),
                .active      (src_act),
                .en_q        (en_arr[k]),
                .pend_q      (pend_arr[k]),
                .req         (irq_out[k])
            );

            assign line_en[k*N_SRC +: N_SRC]   = en_arr[k];
            assign line_pend[k*N_SRC +: N_SRC] = pend_arr[k];
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_POL: reg_rdata[N_SRC-1:0] = pol_q;
            SEL_LINE: begin
                reg_rdata[N_SRC-1:0]       = en_arr[line_idx];
                reg_rdata[P_LSB +: N_SRC]  = pend_arr[line_idx];
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int N_SRC  = 9,
    parameter int N_LINE = 3,
    parameter int P_LSB  = 16,
    parameter int DW     = 32,
    parameter int AW     = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic [AW-1:0]           reg_addr,
    input logic                    reg_we,
    input logic [DW-1:0]           reg_wdata,
    input logic [N_LINE-1:0]       irq_out,
    input logic [N_LINE*N_SRC-1:0] line_en,
    input logic [N_LINE*N_SRC-1:0] line_pend,
    input logic [N_SRC-1:0]        src_act
);
    localparam int WORD_W = AW - 2;

    // R1: a reset cycle leaves every request low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (irq_out == '0));

    genvar l, n;
    generate
        for (l = 0; l < N_LINE; l++) begin : g_l
            logic tgt;
            assign tgt = reg_we && (reg_addr[AW-1:2] == WORD_W'(l + 1));

            // R8: init write empties the addressed line
            a_r8_init_clears: assert property (@(posedge clk) disable iff (rst)
                (tgt && reg_wdata[P_LSB +: N_SRC] == '1 && reg_wdata[N_SRC-1:0] == '0)
                |=> (line_en[l*N_SRC +: N_SRC] == '0 && line_pend[l*N_SRC +: N_SRC] == '0));

            for (n = 0; n < N_SRC; n++) begin : g_n
                // R5: pending only rises for an enabled, active source
                a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
                    $rose(line_pend[l*N_SRC+n]) |->
                        $past(line_en[l*N_SRC+n] && src_act[n]));

                // R6: acknowledge clears the bit
                a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
                    (tgt && reg_wdata[P_LSB+n]) |=> !line_pend[l*N_SRC+n]);

                // R5 / R6: without acknowledge a pending bit holds
                a_r6_hold_no_ack: assert property (@(posedge clk) disable iff (rst)
                    (line_pend[l*N_SRC+n] && !(tgt && reg_wdata[P_LSB+n]))
                    |=> line_pend[l*N_SRC+n]);
            end
        end
    endgenerate
endmodule

bind irq_router irq_router_chk #(
    .N_SRC  (N_SRC),
    .N_LINE (N_LINE),
    .P_LSB  (P_LSB),
    .DW     (DW),
    .AW     (AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .line_en   (line_en),
    .line_pend (line_pend),
    .src_act   (src_act)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  src_raw = '0;
    logic [2:0]  irq_out;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_router i_irq_router (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_raw   (src_raw),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic act_high(input int n, input bit p);
        if (n == 1 || n == 8) return 1'b1;
        if (n == 2) return 1'b0;
        return p;
    endfunction

    function automatic logic [8:0] idle_vec(input bit p);
        logic [8:0] v;
        for (int k = 0; k < 9; k++) v[k] = ~act_high(k, p);
        return v;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] lw;
        logic [31:0] bitn;
        logic        hi;
        string       preq;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq", {29'd0, irq_out}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd(5'(a * 4), r);
            check("R1 read", r, 32'd0);
        end

        // R2: polarity readback, upper bits zero
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, r);
        check("R2 readback", r, 32'h0000_01FF);
        // R4: line register layout, enables stored, pending acked
        src_raw = idle_vec(1'b1);
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, r);
        check("R4 layout", r, 32'h0000_01FF);
        wr(5'h08, 32'h01FF_0000);

        // R10: unmapped address
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, r);
        check("R10 read", r, 32'd0);
        rd(5'h1C, r);
        check("R10 read hi", r, 32'd0);
        rd(5'h00, r);
        check("R10 pol untouched", r, 32'h0000_01FF);
        rd(5'h04, r);
        check("R10 line untouched", r, 32'd0);

        // Sweep every line, source and polarity setting
        for (int l = 0; l < 3; l++) begin
            for (int n = 0; n < 9; n++) begin
                for (int p = 0; p < 2; p++) begin
                    lw   = 32'((l + 1) * 4);
                    bitn = 32'd1 << n;
                    hi   = act_high(n, p[0]);
                    preq = (n == 1 || n == 2 || n == 8) ? "R3" : "R2";
                    src_raw = idle_vec(p[0]);
                    wr(5'h00, p[0] ? 32'h1FF : 32'h0);
                    for (int k = 0; k < 3; k++)
                        wr(5'((k + 1) * 4), 32'h01FF_0000 | ((k == l) ? bitn : 32'd0));
                    repeat (4) @(negedge clk);
                    wr(lw[4:0], 32'h01FF_0000 | bitn);
                    check("R7 idle", {29'd0, irq_out}, 32'd0);

                    src_raw[n] = hi;
                    repeat (2) @(negedge clk);
                    check("R9 two edges", {29'd0, irq_out}, 32'd0);
                    @(negedge clk);
                    check({preq, " R7 irq"}, {29'd0, irq_out}, 32'd1 << l);
                    rd(lw[4:0], r);
                    check("R4 pending", r, (bitn << 16) | bitn);

                    src_raw[n] = ~hi;
                    repeat (4) @(negedge clk);
                    check("R5 latched", {29'd0, irq_out}, 32'd1 << l);

                    wr(lw[4:0], bitn);
                    rd(lw[4:0], r);
                    check("R6 zero write", r, (bitn << 16) | bitn);

                    wr(lw[4:0], (bitn << 16) | bitn);
                    rd(lw[4:0], r);
                    check("R6 ack", r, bitn);
                    check("R7 cleared", {29'd0, irq_out}, 32'd0);

                    src_raw[n] = hi;
                    repeat (3) @(negedge clk);
                    wr(lw[4:0], (bitn << 16) | bitn);
                    rd(lw[4:0], r);
                    check("R6 ack active", r, bitn);
                    @(negedge clk);
                    rd(lw[4:0], r);
                    check("R6 reassert", r, (bitn << 16) | bitn);

                    wr(lw[4:0], 32'h01FF_0000);
                    src_raw = idle_vec(p[0]);
                end
            end
        end

        // R8: init of one line leaves another alone
        wr(5'h00, 32'h1FF);
        src_raw = idle_vec(1'b1);
        wr(5'h04, 32'h01FF_0008);
        wr(5'h08, 32'h01FF_0008);
        wr(5'h0C, 32'h01FF_0000);
        src_raw[3] = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 both pending", {29'd0, irq_out}, 32'd3);
        wr(5'h04, 32'h01FF_0000);
        rd(5'h04, r);
        check("R8 cleared", r, 32'd0);
        rd(5'h08, r);
        check("R8 other line", r, 32'h0008_0008);
        check("R8 irq", {29'd0, irq_out}, 32'd2);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule